// File: doc/BRIEF.md
# Floating-Point Min/Max Unit

This block returns the smaller or the larger of two IEEE-754 operands. One control bit picks 32-bit or 64-bit operands, and a second control bit picks minimum or maximum. Each operation is presented with an input strobe. One clock later the block presents the result word and an invalid-operation flag, together with an output strobe.

Numbers are ordered by value. Negative zero counts as strictly below positive zero. A lone quiet NaN gives way to the numeric operand. A lone signaling NaN also gives way, but it raises the flag. Any pair of NaNs yields a fixed all-ones NaN, so no payload travels from an input to the result. Between strobes, the result and the flag hold their last values.

Top module: `fp_minmax_unit`

## Requirements
- R1: With two non-NaN operands, `sel_max`=0 returns the operand of lower value and `sel_max`=1 returns the higher one. The order is sign-magnitude: for two negatives, the larger magnitude is the smaller value. Infinities are the extreme values, and denormals order by value.
- R2: Negative zero is strictly less than positive zero. The minimum of the two zeros is -0 in either operand order, the maximum is +0 in either order, and the flag stays clear.
- R3: When one operand is a quiet NaN and the other is a number, the number is returned and `invalid` is 0.
- R4: When one operand is a signaling NaN and the other is a number, the number is returned and `invalid` is 1.
- R5: When both operands are NaN, the result is all ones across the active width: 0x00000000FFFFFFFF in 32-bit mode and all 64 bits in 64-bit mode. `invalid` is 1 if either NaN is signaling and 0 if both are quiet.
- R6: A NaN has an all-ones exponent and a nonzero fraction. It is quiet when the top fraction bit is set (bit 22 in 32-bit mode, bit 51 in 64-bit mode) and signaling when that bit is clear. Examples: 0xFFC00000 is quiet and 0xFFB00000 is signaling; 0xFFF8000000000000 is quiet and 0xFFF7000000000000 is signaling.
- R7: With `dbl`=0, bits 63:32 of both operands have no effect, and bits 63:32 of the result are 0. With `dbl`=1, all 64 bits are used.
- R8: `out_valid` is 1 exactly one clock after `in_valid` and 0 otherwise. `result` and `invalid` change only in that cycle and hold their values between operations.
- R9: A synchronous active-high `rst` clears `out_valid`, `invalid` and `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| opnd_a | input | 64 | First operand (low 32 bits in 32-bit mode) |
| opnd_b | input | 64 | Second operand (low 32 bits in 32-bit mode) |
| sel_max | input | 1 | 0 = minimum, 1 = maximum |
| dbl | input | 1 | 0 = 32-bit format, 1 = 64-bit format |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| result | output | 64 | Selected operand or default NaN |
| invalid | output | 1 | Invalid-operation flag for the last result |

## Verification
The hardest situation to reach from the ports is 32-bit mode when the unused upper operand bits themselves look like a 64-bit NaN or infinity. A leak from the wrong format's classifier would only show up there. The bench gives every 32-bit vector upper halves that are, respectively, a 64-bit signaling NaN pattern and a 64-bit negative infinity. It then sweeps every ordered pair from a set of zeros, unit values, denormals, extremes, infinities and both NaN kinds of both signs, in both modes and for both operations.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;
  localparam int unsigned WORD_W = 64;
  localparam int unsigned SP_EXP_W = 8;
  localparam int unsigned SP_FRAC_W = 23;
  localparam int unsigned DP_EXP_W = 11;
  localparam int unsigned DP_FRAC_W = 52;
  localparam int unsigned SP_W = 1 + SP_EXP_W + SP_FRAC_W;

  typedef struct packed {
    logic              sign;
    logic              is_nan;
    logic              is_snan;
    logic [WORD_W-2:0] mag;
  } fp_info_t;
endpackage

// File: rtl/fpmm_classify.sv
module fpmm_classify
  import fpmm_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23
) (
  input  logic [WORD_W-1:0] opnd,
  output fp_info_t          info
);
  localparam int unsigned FMT_W = 1 + EXP_W + FRAC_W;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  assign exp_f  = opnd[FMT_W-2:FRAC_W];
  assign frac_f = opnd[FRAC_W-1:0];

  always_comb begin
    info         = '0;
    info.sign    = opnd[FMT_W-1];
    info.is_nan  = (&exp_f) && (|frac_f);
    info.is_snan = (&exp_f) && (|frac_f) && !frac_f[FRAC_W-1];
    info.mag     = (WORD_W-1)'(opnd[FMT_W-2:0]);
  end
endmodule

// File: rtl/fpmm_order.sv
module fpmm_order
  import fpmm_pkg::*;
(
  input  fp_info_t a,
  input  fp_info_t b,
  output logic     a_lt_b
);
  function automatic logic less_than(input fp_info_t x, input fp_info_t y);
    if (x.sign != y.sign) return x.sign;
    if (x.sign)           return x.mag > y.mag;
    return x.mag < y.mag;
  endfunction

  assign a_lt_b = less_than(a, b);
endmodule

// File: rtl/fpmm_select.sv
module fpmm_select
  import fpmm_pkg::*;
(
  input  logic [WORD_W-1:0] a_word,
  input  logic [WORD_W-1:0] b_word,
  input  fp_info_t          a_info,
  input  fp_info_t          b_info,
  input  logic              a_lt_b,
  input  logic              sel_max,
  input  logic              dbl,
  output logic [WORD_W-1:0] res,
  output logic              inv,
  output logic              both_nan,
  output logic              one_nan
);
  logic [WORD_W-1:0] dflt_nan;
  logic              pick_a;

  assign dflt_nan = dbl ? '1 : WORD_W'({SP_W{1'b1}});
  assign both_nan = a_info.is_nan && b_info.is_nan;
  assign one_nan  = a_info.is_nan ^ b_info.is_nan;
  assign pick_a   = sel_max ? !a_lt_b : a_lt_b;

  always_comb begin
    inv = a_info.is_snan || b_info.is_snan;
    if (both_nan)           res = dflt_nan;
    else if (a_info.is_nan) res = b_word;
    else if (b_info.is_nan) res = a_word;
    else                    res = pick_a ? a_word : b_word;
  end

  always_comb begin
    if (!a_info.is_nan && !b_info.is_nan)
      a_r6_no_flag_on_numbers: assert (!inv);
  end
endmodule

// File: rtl/fp_minmax_unit.sv
module fp_minmax_unit
  import fpmm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] opnd_a,
  input  logic [WORD_W-1:0] opnd_b,
  input  logic              sel_max,
  input  logic              dbl,
  output logic              out_valid,
  output logic [WORD_W-1:0] result,
  output logic              invalid
);
  localparam int unsigned N_OPND = 2;

  logic [WORD_W-1:0] raw_w  [N_OPND];
  logic [WORD_W-1:0] eff_w  [N_OPND];
  fp_info_t          sp_inf [N_OPND];
  fp_info_t          dp_inf [N_OPND];
  fp_info_t          sel_inf[N_OPND];

  assign raw_w[0] = opnd_a;
  assign raw_w[1] = opnd_b;

  for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
    assign eff_w[g] = dbl ? raw_w[g] : WORD_W'(raw_w[g][SP_W-1:0]);
    fpmm_classify #(.EXP_W(SP_EXP_W), .FRAC_W(SP_FRAC_W)) u_sp (
      .opnd(eff_w[g]), .info(sp_inf[g]));
    fpmm_classify #(.EXP_W(DP_EXP_W), .FRAC_W(DP_FRAC_W)) u_dp (
      .opnd(eff_w[g]), .info(dp_inf[g]));
    assign sel_inf[g] = dbl ? dp_inf[g] : sp_inf[g];
  end

  logic              a_lt_b;
  logic [WORD_W-1:0] res_n;
  logic              inv_n;
  logic              both_nan_w;
  logic              one_nan_w;

  fpmm_order u_order (.a(sel_inf[0]), .b(sel_inf[1]), .a_lt_b(a_lt_b));

  fpmm_select u_select (
    .a_word(eff_w[0]), .b_word(eff_w[1]),
    .a_info(sel_inf[0]), .b_info(sel_inf[1]),
    .a_lt_b(a_lt_b), .sel_max(sel_max), .dbl(dbl),
    .res(res_n), .inv(inv_n), .both_nan(both_nan_w), .one_nan(one_nan_w));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      invalid   <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= res_n;
        invalid <= inv_n;
      end
    end
  end

  // R8: the output strobe follows the input strobe by one cycle
  a_r8_latency: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(invalid)));
  // R7: the upper half of a 32-bit result is zero
  a_r7_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !dbl) |=> (result[WORD_W-1:SP_W] == '0));
  // R5: a 64-bit NaN pair gives the all-ones word
  a_r5_default_nan: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dbl && both_nan_w) |=> (&result));
  // R3: a lone quiet NaN leaves the flag clear
  a_r3_quiet_silent: assert property (@(posedge clk) disable iff (rst)
    (in_valid && one_nan_w && !sel_inf[0].is_snan && !sel_inf[1].is_snan)
      |=> !invalid);
  // R4: a lone signaling NaN raises the flag and returns a number
  a_r4_snan_flags: assert property (@(posedge clk) disable iff (rst)
    (in_valid && one_nan_w && (sel_inf[0].is_snan || sel_inf[1].is_snan))
      |=> (invalid && (result == $past(sel_inf[0].is_nan ? eff_w[1] : eff_w[0]))));
endmodule

// File: tb/fp_minmax_unit_test.sv
module fp_minmax_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVAL = 12;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [63:0] opnd_a, opnd_b;
  logic        sel_max, dbl;
  logic        out_valid;
  logic [63:0] result;
  logic        invalid;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_minmax_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .sel_max(sel_max), .dbl(dbl), .out_valid(out_valid), .result(result),
    .invalid(invalid));

  function automatic logic [63:0] sp_vec(input int i);
    case (i)
      0: return 64'h0000_0000;  1: return 64'h8000_0000;
      2: return 64'h3f80_0000;  3: return 64'hbf80_0000;
      4: return 64'h8000_0001;  5: return 64'h7f80_0000;
      6: return 64'hff80_0000;  7: return 64'hffc0_0000;
      8: return 64'hffb0_0000;  9: return 64'h7f7f_ffff;
      10: return 64'h7fc0_0001; default: return 64'h7f80_0001;
    endcase
  endfunction

  function automatic logic [63:0] dp_vec(input int i);
    case (i)
      0: return 64'h0000_0000_0000_0000;  1: return 64'h8000_0000_0000_0000;
      2: return 64'h3ff0_0000_0000_0000;  3: return 64'hbff0_0000_0000_0000;
      4: return 64'h8000_0000_0000_0001;  5: return 64'h7ff0_0000_0000_0000;
      6: return 64'hfff0_0000_0000_0000;  7: return 64'hfff8_0000_0000_0000;
      8: return 64'hfff7_0000_0000_0000;  9: return 64'h7fef_ffff_ffff_ffff;
      10: return 64'h7ff8_0000_0000_0001; default: return 64'h7ff0_0000_0000_0001;
    endcase
  endfunction

  // value of a 32-bit word as a real; infinities map far beyond the finite range
  function automatic real sp_real(input logic [31:0] w);
    real m, v;
    int  e;
    e = int'(w[30:23]);
    m = real'(w[22:0]) / 8388608.0;
    if (e == 255)    v = 1.0e300;
    else if (e == 0) v = m * (2.0 ** (-126));
    else             v = (1.0 + m) * (2.0 ** (e - 127));
    return w[31] ? -v : v;
  endfunction

  task automatic expect_op(input logic [63:0] a, input logic [63:0] b,
                           input logic mx, input logic d,
                           output logic [63:0] er, output logic ei, output string req);
    logic [63:0] wa, wb;
    logic na, nb, qa, qb, a_less, b_less;
    real va, vb;
    wa = d ? a : {32'h0, a[31:0]};
    wb = d ? b : {32'h0, b[31:0]};
    if (d) begin
      na = (wa[62:52] == 11'h7ff) && (wa[51:0] != 0); qa = wa[51];
      nb = (wb[62:52] == 11'h7ff) && (wb[51:0] != 0); qb = wb[51];
      va = $bitstoreal(wa); vb = $bitstoreal(wb);
    end else begin
      na = (wa[30:23] == 8'hff) && (wa[22:0] != 0); qa = wa[22];
      nb = (wb[30:23] == 8'hff) && (wb[22:0] != 0); qb = wb[22];
      va = sp_real(wa[31:0]); vb = sp_real(wb[31:0]);
    end
    if (na && nb) begin
      er = d ? 64'hffff_ffff_ffff_ffff : 64'h0000_0000_ffff_ffff;
      ei = !qa || !qb; req = "R5";
    end else if (na || nb) begin
      er = na ? wb : wa;
      ei = na ? !qa : !qb; req = ei ? "R4" : "R3";
    end else begin
      a_less = (va < vb) || (va == vb && va == 0.0 && wa[63-(d ? 0 : 32)] && !wb[63-(d ? 0 : 32)]);
      b_less = (vb < va) || (va == vb && va == 0.0 && wb[63-(d ? 0 : 32)] && !wa[63-(d ? 0 : 32)]);
      if (a_less)      er = mx ? wb : wa;
      else if (b_less) er = mx ? wa : wb;
      else             er = wa;
      ei = 1'b0;
      req = (va == 0.0 && vb == 0.0) ? "R2" : "R1";
    end
    if (!d) req = {req, "/R7"};
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_one(input logic [63:0] a, input logic [63:0] b,
                         input logic mx, input logic d);
    logic [63:0] er;
    logic ei;
    string req;
    expect_op(a, b, mx, d, er, ei, req);
    @(negedge clk);
    opnd_a = a; opnd_b = b; sel_max = mx; dbl = d; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " R8 valid"}, 64'(out_valid), 64'd1);
    check({req, " result"}, result, er);
    check({req, " R6 flag"}, 64'(invalid), 64'(ei));
    opnd_a = ~a; opnd_b = ~b;
    @(negedge clk);
    check("R8 strobe drop", 64'(out_valid), 64'd0);
    check("R8 hold", result, er);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; opnd_a = '0; opnd_b = '0; sel_max = 1'b0; dbl = 1'b0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 out_valid", 64'(out_valid), 64'd0);
    check("R9 invalid", 64'(invalid), 64'd0);
    check("R9 result", result, 64'd0);
    rst = 1'b0;
    for (int d = 0; d < 2; d++)
      for (int mx = 0; mx < 2; mx++)
        for (int i = 0; i < NVAL; i++)
          for (int j = 0; j < NVAL; j++) begin
            if (d == 1) run_one(dp_vec(i), dp_vec(j), mx[0], 1'b1);
            else        run_one({32'hfff7_0000, sp_vec(i)[31:0]},
                                {32'hfff0_0000, sp_vec(j)[31:0]}, mx[0], 1'b0);
          end
    // R9: reset after activity clears flag and strobe
    @(negedge clk);
    opnd_a = 64'hfff7_0000_0000_0000; opnd_b = 64'h0; dbl = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    check("R9 flag cleared", 64'(invalid), 64'd0);
    check("R9 valid cleared", 64'(out_valid), 64'd0);
    rst = 1'b0;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule